// File: doc/BRIEF.md
# Endpoint-Zero Control and Status Register

This block holds the eight-bit control and status byte for the default control endpoint of a USB device-mode controller. On one side a CPU reaches it through a plain register port: a read strobe with combinational read data, and a write strobe with write data. On the other side a control-transfer packet engine reports what happened on the bus through single-cycle event pulses. These pulses say that a packet was received, a stall handshake was sent, a transaction ended early, a transmit packet was consumed, or the status stage finished. In return the block gives the engine its level requests: transmit ready, stall, data end and receive pending.

Software and hardware share every flag under fixed rules. Two bits of the byte are clear strobes that act on read-only flags. Two request bits are dropped by hardware when the engine reports completion. When a flag is set and cleared in the same cycle, the set is kept, so no event is lost. Three of the hardware events also raise a single-cycle endpoint-zero interrupt pulse. There is no data stream at this boundary, so every pin is a plain control or status level or strobe.

Top module: `ep0_csr_reg`

## Requirements
- R1: After reset every flag is 0, every request output is 0 and the interrupt output is 0.
- R2: While the read strobe is high, the read data gives the live flags with send stall in bit 5, setup end in bit 4, data end in bit 3, stalled in bit 2, transmit ready in bit 1 and receive ready in bit 0. Bits 7 and 6 read as 0. While the read strobe is low, the read data is all zeros.
- R3: A packet-received event sets receive ready (bit 0). A write with bit 6 at 1 clears it. A write with bit 6 at 0 leaves it unchanged, and a write never sets it.
- R4: An early-end event sets setup end (bit 4) only while data end is 0. A write with bit 7 at 1 clears setup end, and a write with bit 7 at 0 leaves it unchanged.
- R5: Send stall (bit 5) takes the value of bit 5 on every write and drives the stall request output. A stall-sent event clears it.
- R6: A stall-sent event sets stalled (bit 2). A write with bit 2 at 0 clears it, and a write with bit 2 at 1 leaves it unchanged.
- R7: A write with bit 1 at 1 sets transmit ready, which drives the transmit request output. A write with bit 1 at 0 has no effect on it. A transmit-done event clears it.
- R8: A write with bit 3 at 1 sets data end, which drives the data-end output. A write with bit 3 at 0 has no effect on it. A status-done event clears it.
- R9: When a set condition and a clear condition of the same flag fall in the same cycle, the flag ends up at 1.
- R10: The interrupt output is high for exactly one cycle, the cycle after any of these events: a packet received, an early end that sets setup end, or a transmit-done event while transmit ready is 1. Software writes and stall events never raise it.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd | input | 1 | CPU read strobe |
| reg_wr | input | 1 | CPU write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data, zero when not reading |
| evt_rx_pkt | input | 1 | Engine: data packet received |
| evt_stall_sent | input | 1 | Engine: stall handshake transmitted |
| evt_early_end | input | 1 | Engine: control transaction ended early |
| evt_tx_done | input | 1 | Engine: transmit packet consumed |
| evt_status_done | input | 1 | Engine: status stage completed |
| tx_req_o | output | 1 | Transmit packet ready request |
| stall_req_o | output | 1 | Send stall request |
| data_end_o | output | 1 | Last data packet marker |
| rx_full_o | output | 1 | Received packet awaiting unload |
| irq_o | output | 1 | Endpoint-zero interrupt pulse |

## Verification
The byte is exercised with write patterns that pair a target bit with its inverse. These show that clear strobes act only on a 1, that the stalled flag clears only on a 0, and that the ready and data-end bits ignore a 0. Each engine event is pulsed once on its own, which ties each interrupt pulse to its source event. An early end is sent once with data end clear and once with it set, and only the first must raise setup end. Finally, each set event is driven in the same cycle as a write that would clear the same flag, to confirm that the set wins.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 6;
  localparam int NUM_IRQ   = 3;
  // stored flag positions
  localparam int B_RXRDY   = 0;
  localparam int B_TXRDY   = 1;
  localparam int B_STALLED = 2;
  localparam int B_DATAEND = 3;
  localparam int B_SETEND  = 4;
  localparam int B_STALL   = 5;
  // write-only clear strobes
  localparam int B_RXCLR   = 6;
  localparam int B_SECLR   = 7;
endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |src_i;
  end
endmodule

// File: rtl/ep0_csr_reg.sv
module ep0_csr_reg
  import ep0_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             evt_rx_pkt,
  input  logic             evt_stall_sent,
  input  logic             evt_early_end,
  input  logic             evt_tx_done,
  input  logic             evt_status_done,
  output logic             tx_req_o,
  output logic             stall_req_o,
  output logic             data_end_o,
  output logic             rx_full_o,
  output logic             irq_o
);
  localparam int PAD_W = REG_W - NUM_FLAGS;

  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] set_v;
  logic [NUM_FLAGS-1:0] clr_v;
  logic [REG_W-1:0]     wr_one;
  logic [REG_W-1:0]     wr_zero;
  logic [NUM_IRQ-1:0]   irq_src;
  logic                 early_set;
  logic                 tx_fin;

  assign wr_one    = reg_wr ? reg_wdata  : '0;
  assign wr_zero   = reg_wr ? ~reg_wdata : '0;
  assign early_set = evt_early_end & ~flag_q[B_DATAEND];
  assign tx_fin    = evt_tx_done & flag_q[B_TXRDY];

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[B_RXRDY]   = evt_rx_pkt;
    clr_v[B_RXRDY]   = wr_one[B_RXCLR];
    set_v[B_SETEND]  = early_set;
    clr_v[B_SETEND]  = wr_one[B_SECLR];
    set_v[B_STALL]   = wr_one[B_STALL];
    clr_v[B_STALL]   = wr_zero[B_STALL] | evt_stall_sent;
    set_v[B_STALLED] = evt_stall_sent;
    clr_v[B_STALLED] = wr_zero[B_STALLED];
    set_v[B_TXRDY]   = wr_one[B_TXRDY];
    clr_v[B_TXRDY]   = evt_tx_done;
    set_v[B_DATAEND] = wr_one[B_DATAEND];
    clr_v[B_DATAEND] = evt_status_done;
  end

  ep0_flag_cell #(.W(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (flag_q)
  );

  assign irq_src = {tx_fin, early_set, evt_rx_pkt};

  ep0_irq_gen #(.N(NUM_IRQ)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (irq_src),
    .irq_o (irq_o)
  );

  assign reg_rdata   = reg_rd ? {{PAD_W{1'b0}}, flag_q} : '0;
  assign tx_req_o    = flag_q[B_TXRDY];
  assign stall_req_o = flag_q[B_STALL];
  assign data_end_o  = flag_q[B_DATAEND];
  assign rx_full_o   = flag_q[B_RXRDY];
endmodule

// File: rtl/ep0_csr_chk.sv
module ep0_csr_chk
  import ep0_csr_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_rd,
  input logic                 reg_wr,
  input logic [REG_W-1:0]     reg_wdata,
  input logic [REG_W-1:0]     reg_rdata,
  input logic                 evt_rx_pkt,
  input logic                 evt_stall_sent,
  input logic                 evt_early_end,
  input logic                 evt_tx_done,
  input logic                 evt_status_done,
  input logic                 tx_req_o,
  input logic                 stall_req_o,
  input logic                 data_end_o,
  input logic                 rx_full_o,
  input logic                 irq_o,
  input logic [NUM_FLAGS-1:0] flag_q
);
  // R2
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:NUM_FLAGS] == '0);
  // R2
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);
  // R3
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_pkt |=> rx_full_o);
  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_o && !(reg_wr && reg_wdata[B_RXCLR]) |=> rx_full_o);
  // R4
  setend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_early_end && data_end_o && !flag_q[B_SETEND] |=> !flag_q[B_SETEND]);
  // R5
  stall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stall_sent && !(reg_wr && reg_wdata[B_STALL]) |=> !stall_req_o);
  // R6
  stalled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stall_sent |=> flag_q[B_STALLED]);
  // R7
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_done && !(reg_wr && reg_wdata[B_TXRDY]) |=> !tx_req_o);
  // R8
  dend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_status_done && !(reg_wr && reg_wdata[B_DATAEND]) |=> !data_end_o);
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(evt_rx_pkt || (evt_early_end && !data_end_o)
                    || (evt_tx_done && tx_req_o)));
endmodule

bind ep0_csr_reg ep0_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_rx_pkt(evt_rx_pkt),
  .evt_stall_sent(evt_stall_sent), .evt_early_end(evt_early_end),
  .evt_tx_done(evt_tx_done), .evt_status_done(evt_status_done),
  .tx_req_o(tx_req_o), .stall_req_o(stall_req_o), .data_end_o(data_end_o),
  .rx_full_o(rx_full_o), .irq_o(irq_o), .flag_q(flag_q)
);

// File: tb/test_ep0_csr_reg.sv
module test_ep0_csr_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       evt_rx_pkt = 0, evt_stall_sent = 0, evt_early_end = 0;
  logic       evt_tx_done = 0, evt_status_done = 0;
  logic       tx_req_o, stall_req_o, data_end_o, rx_full_o, irq_o;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  ep0_csr_reg i_ep0_csr_reg (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_rx_pkt(evt_rx_pkt),
    .evt_stall_sent(evt_stall_sent), .evt_early_end(evt_early_end),
    .evt_tx_done(evt_tx_done), .evt_status_done(evt_status_done),
    .tx_req_o(tx_req_o), .stall_req_o(stall_req_o), .data_end_o(data_end_o),
    .rx_full_o(rx_full_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one bus cycle; ev = {status_done, tx_done, early_end, stall_sent, rx_pkt}
  task automatic cyc(input logic wr, input logic [7:0] wd, input logic [4:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd;
    {evt_status_done, evt_tx_done, evt_early_end, evt_stall_sent, evt_rx_pkt} = ev;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
    {evt_status_done, evt_tx_done, evt_early_end, evt_stall_sent, evt_rx_pkt} = '0;
    #1;
  endtask

  task automatic rd_exp(input logic [7:0] val, input string tag);
    exp_t e;
    e.val = val; e.tag = tag;
    exp_q.push_back(e);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    #1;
  endtask

  // monitor: compares read data against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (reg_rd) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: read with empty scoreboard, actual %02h expected none", reg_rdata);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(reg_rdata, e.val, e.tag);
        end
      end
    end
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk({3'b0, tx_req_o, stall_req_o, data_end_o, rx_full_o, irq_o}, 8'h00, "R1 outputs");
    rd_exp(8'h00, "R1 read");
    chk(reg_rdata, 8'h00, "R2 idle read data");

    // R3 / R10 receive
    cyc(0, 8'h00, 5'b00001);
    chk({7'b0, irq_o}, 8'h01, "R10 irq on rx");
    chk({7'b0, rx_full_o}, 8'h01, "R3 rx_full");
    rd_exp(8'h01, "R3 rx set read");
    chk({7'b0, irq_o}, 8'h00, "R10 single pulse");
    cyc(1, 8'h00, 5'b0);
    rd_exp(8'h01, "R3 write zero keeps rx");
    cyc(1, 8'hC0, 5'b0);
    rd_exp(8'h00, "R3 clear strobe");

    // R7 transmit
    cyc(1, 8'h02, 5'b0);
    chk({7'b0, irq_o}, 8'h00, "R10 no irq on write");
    chk({7'b0, tx_req_o}, 8'h01, "R7 tx_req set");
    rd_exp(8'h02, "R7 tx read");
    cyc(1, 8'h00, 5'b0);
    rd_exp(8'h02, "R7 write zero keeps tx");
    cyc(0, 8'h00, 5'b01000);
    chk({7'b0, irq_o}, 8'h01, "R10 irq on tx done");
    chk({7'b0, tx_req_o}, 8'h00, "R7 tx cleared");

    // R8 / R4 data end blocks setup end
    cyc(1, 8'h0A, 5'b0);
    chk({7'b0, data_end_o}, 8'h01, "R8 data_end set");
    cyc(0, 8'h00, 5'b00100);
    chk({7'b0, irq_o}, 8'h00, "R4 no irq when data end set");
    rd_exp(8'h0A, "R4 setup end blocked");
    cyc(1, 8'h00, 5'b0);
    rd_exp(8'h0A, "R8 write zero keeps data end");
    cyc(0, 8'h00, 5'b10000);
    rd_exp(8'h02, "R8 status done clears");
    cyc(0, 8'h00, 5'b01000);
    rd_exp(8'h00, "R7 tx done clears");

    // R4 setup end
    cyc(0, 8'h00, 5'b00100);
    chk({7'b0, irq_o}, 8'h01, "R10 irq on setup end");
    rd_exp(8'h10, "R4 setup end set");
    cyc(1, 8'h00, 5'b0);
    rd_exp(8'h10, "R4 write zero keeps");
    cyc(1, 8'h80, 5'b0);
    rd_exp(8'h00, "R4 clear strobe");

    // R5 / R6 stall
    cyc(1, 8'h20, 5'b0);
    chk({7'b0, stall_req_o}, 8'h01, "R5 stall request");
    rd_exp(8'h20, "R5 stall read");
    cyc(0, 8'h00, 5'b00010);
    chk({7'b0, irq_o}, 8'h00, "R10 no irq on stall");
    chk({7'b0, stall_req_o}, 8'h00, "R5 stall cleared");
    rd_exp(8'h04, "R6 stalled set");
    cyc(1, 8'h04, 5'b0);
    rd_exp(8'h04, "R6 write one keeps");
    cyc(1, 8'h00, 5'b0);
    rd_exp(8'h00, "R6 write zero clears");

    // R9 set wins
    cyc(1, 8'h40, 5'b00001);
    rd_exp(8'h01, "R9 rx set beats clear");
    cyc(1, 8'h00, 5'b00010);
    rd_exp(8'h05, "R9 stalled set beats clear");
    cyc(1, 8'hC2, 5'b01000);
    rd_exp(8'h02, "R9 tx write beats done");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule